// File: doc/BRIEF.md
# PAL Monochrome Sync and Level Generator

This block produces the timing for a non-interlaced, 312-line, 50 Hz PAL picture from a 10 MHz tick clock. It counts ticks within a 640-tick scanline and scanlines within a frame. From those counts it drives a 2-bit level code into an external resistor ladder. Code 00 is sync at 0 V, code 01 is black at about 0.3 V, and code 11 is white at 1.0 V.

A downstream pixel source watches three outputs: the line-start and frame-start strobes, the horizontal active-window flag and the active-line number. While the window is open, the source presents one pixel bit per tick on `pixel_in`. That bit reaches the most significant bit of the level code in the same cycle.

The vertical interval occupies lines 0 to 7 as sixteen 320-tick half-lines: six equalizing pulses, then five broad sync pulses, then five equalizing pulses. Lines 8 to 22 and 310 to 311 carry only the horizontal sync pulse. Lines 23 to 309 use the four-phase layout: sync, left border, picture, right border.

Top module: `pal_sync_gen`

A state machine names the segment of the line that the current tick falls in. Its states are:

- SEG_HSYNC: line sync.
- SEG_LEFT: left border.
- SEG_ACTIVE: picture.
- SEG_RIGHT: right border.
- SEG_BLANK: black after sync on a blanked line.
- SEG_EQ_LO and SEG_EQ_HI: the low and high parts of an equalizing pulse.
- SEG_BROAD_LO and SEG_BROAD_HI: the low and high parts of a broad pulse.

The transitions are:

- On a picture line: HSYNC→LEFT at tick 40, LEFT→ACTIVE at tick 160, ACTIVE→RIGHT at tick 600, and RIGHT→HSYNC or →EQ_LO at the line wrap.
- On a blanked line: HSYNC→BLANK at tick 40, and BLANK→HSYNC or →EQ_LO at the wrap.
- In the vertical interval: EQ_LO→EQ_HI after 20 ticks, and BROAD_LO→BROAD_HI after 273 ticks. At each half-line boundary the machine enters EQ_LO or BROAD_LO, and it enters HSYNC when line 8 starts.
- Reset places the machine in BLANK on the last tick of line 311.

## Requirements
- R1: Every line is 640 ticks long. `line_start` is high for exactly one cycle, at tick 0 of every line. The first pulse comes on the first clock edge after reset is released.
- R2: A frame is 312 lines. `frame_start` is high only together with `line_start`, at tick 0 of line 0, once every 199,680 ticks.
- R3: On lines 23 to 309, `level` is 00 for ticks 0–39 and 01 for ticks 40–159 and 600–639.
- R4: `active_win` is 1 exactly for ticks 160–599 of lines 23 to 309. While it is 1, `level` equals {`pixel_in`, 1}: 11 is white and 01 is black. The code 10 never appears.
- R5: On lines 8–22 and 310–311, `level` is 00 for ticks 0–39 and 01 for ticks 40–639. On these lines `active_win` stays 0 and `pixel_in` has no effect.
- R6: Lines 0–7 form half-lines 0–15, numbered line×2 plus 1 for ticks 320–639. Half-lines 0–5 and 11–15 are equalizing pulses: `level` is 00 for the first 20 ticks of the half-line and 01 for the remaining 300.
- R7: Half-lines 6–10 (the first half of line 3 through the first half of line 5) are broad pulses: `level` is 00 for the first 273 ticks and 01 for the last 47.
- R8: `active_line` equals the line number minus 23 throughout lines 23–309, giving 0 to 286. It is 0 on every other line.
- R9: While `rst` is high, `level` is 01, and `line_start`, `frame_start`, `active_win` and `active_line` are 0, whatever `pixel_in` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz tick clock |
| rst | input | 1 | Synchronous reset, active high |
| pixel_in | input | 1 | Pixel bit, used only inside the active window |
| level | output | 2 | Code for the resistor ladder: 00 sync, 01 black, 11 white |
| line_start | output | 1 | One-cycle strobe at tick 0 of each line |
| frame_start | output | 1 | One-cycle strobe at tick 0 of line 0 |
| active_win | output | 1 | High during the picture ticks of a picture line |
| active_line | output | 9 | Picture line number, 0 to 286 |

## Verification
The bench walks one complete frame tick by tick and through the wrap into the next one, so every segment edge is visited.

- Half-line boundaries: a design that miscounts the half-line index would put a broad pulse on line 2 or line 5's second half. The bench predicts the edges at ticks 20, 273 and 320 of lines 0–7 and compares them directly.
- Picture window edges: an off-by-one error at tick 159/160 or 599/600 would leak a pixel into a border or clip one.
- Blanked lines: `pixel_in` is toggled on blanked lines and borders, so a design that forgets to gate it shows white there.
- Frame and line numbering: checks at line 309→310 and at the frame wrap catch a wrong frame length or a wrong active-line base.

// File: rtl/pal_sync_pkg.sv
package pal_sync_pkg;

    // Segment of the line the current tick belongs to
    typedef enum logic [3:0] {
        SEG_HSYNC,
        SEG_LEFT,
        SEG_ACTIVE,
        SEG_RIGHT,
        SEG_BLANK,
        SEG_EQ_LO,
        SEG_EQ_HI,
        SEG_BROAD_LO,
        SEG_BROAD_HI
    } seg_e;

    localparam logic [1:0] LVL_SYNC  = 2'b00;
    localparam logic [1:0] LVL_BLACK = 2'b01;

endpackage

// File: rtl/pal_tick_counter.sv
module pal_tick_counter #(
    parameter int LINE_TICKS = 640,
    localparam int HW = $clog2(LINE_TICKS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [HW-1:0] tick_q,
    output logic [HW-1:0] tick_next,
    output logic          line_wrap
);

    localparam logic [HW-1:0] LAST_TICK = HW'(LINE_TICKS - 1);

    assign line_wrap = (tick_q == LAST_TICK);
    assign tick_next = line_wrap ? '0 : tick_q + 1'b1;

    // Reset parks on the final tick so the first edge after release lands on tick 0
    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= LAST_TICK;
        end else begin
            tick_q <= tick_next;
        end
    end

endmodule

// File: rtl/pal_line_counter.sv
module pal_line_counter #(
    parameter int FRAME_LINES = 312,
    localparam int VW = $clog2(FRAME_LINES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    output logic [VW-1:0] line_q,
    output logic [VW-1:0] line_next
);

    localparam logic [VW-1:0] LAST_LINE = VW'(FRAME_LINES - 1);

    always_comb begin
        if (!advance) begin
            line_next = line_q;
        end else if (line_q == LAST_LINE) begin
            line_next = '0;
        end else begin
            line_next = line_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= LAST_LINE;
        end else begin
            line_q <= line_next;
        end
    end

endmodule

// File: rtl/pal_seg_decoder.sv
module pal_seg_decoder
    import pal_sync_pkg::*;
#(
    parameter int LINE_TICKS         = 640,
    parameter int SYNC_TICKS         = 40,
    parameter int LEFT_TICKS         = 120,
    parameter int ACTIVE_TICKS       = 440,
    parameter int FRAME_LINES        = 312,
    parameter int EQ_PRE_HALVES      = 6,
    parameter int BROAD_HALVES       = 5,
    parameter int EQ_POST_HALVES     = 5,
    parameter int EQ_LOW_TICKS       = 20,
    parameter int BROAD_LOW_TICKS    = 273,
    parameter int TOP_BLANK_END      = 23,
    parameter int BOTTOM_BLANK_START = 310,
    localparam int HW = $clog2(LINE_TICKS),
    localparam int VW = $clog2(FRAME_LINES)
) (
    input  logic [HW-1:0] tick,
    input  logic [VW-1:0] line,
    output seg_e          seg
);

    localparam int HALF_TICKS  = LINE_TICKS / 2;
    localparam int VS_LINES    = (EQ_PRE_HALVES + BROAD_HALVES + EQ_POST_HALVES) / 2;
    localparam int BROAD_FIRST = EQ_PRE_HALVES;
    localparam int BROAD_END   = EQ_PRE_HALVES + BROAD_HALVES;
    localparam int LEFT_END    = SYNC_TICKS + LEFT_TICKS;
    localparam int ACTIVE_END  = LEFT_END + ACTIVE_TICKS;

    always_comb begin
        int ti;
        int li;
        int half;
        int hpos;
        int hidx;
        ti   = int'(tick);
        li   = int'(line);
        half = (ti >= HALF_TICKS) ? 1 : 0;
        hpos = ti - half * HALF_TICKS;
        hidx = li * 2 + half;
        seg  = SEG_BLANK;
        if (li < VS_LINES) begin
            // Vertical interval: each half-line is one pulse
            if (hidx >= BROAD_FIRST && hidx < BROAD_END) begin
                seg = (hpos < BROAD_LOW_TICKS) ? SEG_BROAD_LO : SEG_BROAD_HI;
            end else begin
                seg = (hpos < EQ_LOW_TICKS) ? SEG_EQ_LO : SEG_EQ_HI;
            end
        end else if (ti < SYNC_TICKS) begin
            seg = SEG_HSYNC;
        end else if (li < TOP_BLANK_END || li >= BOTTOM_BLANK_START) begin
            seg = SEG_BLANK;
        end else if (ti < LEFT_END) begin
            seg = SEG_LEFT;
        end else if (ti < ACTIVE_END) begin
            seg = SEG_ACTIVE;
        end else begin
            seg = SEG_RIGHT;
        end
    end

endmodule

// File: rtl/pal_sync_gen.sv
module pal_sync_gen
    import pal_sync_pkg::*;
#(
    parameter int LINE_TICKS         = 640,
    parameter int SYNC_TICKS         = 40,
    parameter int LEFT_TICKS         = 120,
    parameter int ACTIVE_TICKS       = 440,
    parameter int FRAME_LINES        = 312,
    parameter int EQ_PRE_HALVES      = 6,
    parameter int BROAD_HALVES       = 5,
    parameter int EQ_POST_HALVES     = 5,
    parameter int EQ_LOW_TICKS       = 20,
    parameter int BROAD_LOW_TICKS    = 273,
    parameter int TOP_BLANK_END      = 23,
    parameter int BOTTOM_BLANK_START = 310,
    localparam int AW = $clog2(BOTTOM_BLANK_START - TOP_BLANK_END)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pixel_in,
    output logic [1:0]    level,
    output logic          line_start,
    output logic          frame_start,
    output logic          active_win,
    output logic [AW-1:0] active_line
);

    localparam int HW = $clog2(LINE_TICKS);
    localparam int VW = $clog2(FRAME_LINES);

    logic [HW-1:0] tick_q;
    logic [HW-1:0] tick_next;
    logic          line_wrap;
    logic [VW-1:0] line_q;
    logic [VW-1:0] line_next;
    seg_e          seg_d;
    seg_e          state_q;

    pal_tick_counter #(.LINE_TICKS(LINE_TICKS)) u_ticks (
        .clk       (clk),
        .rst       (rst),
        .tick_q    (tick_q),
        .tick_next (tick_next),
        .line_wrap (line_wrap)
    );

    pal_line_counter #(.FRAME_LINES(FRAME_LINES)) u_lines (
        .clk       (clk),
        .rst       (rst),
        .advance   (line_wrap),
        .line_q    (line_q),
        .line_next (line_next)
    );

    // Next state is decoded from the counter values the next edge will load
    pal_seg_decoder #(
        .LINE_TICKS         (LINE_TICKS),
        .SYNC_TICKS         (SYNC_TICKS),
        .LEFT_TICKS         (LEFT_TICKS),
        .ACTIVE_TICKS       (ACTIVE_TICKS),
        .FRAME_LINES        (FRAME_LINES),
        .EQ_PRE_HALVES      (EQ_PRE_HALVES),
        .BROAD_HALVES       (BROAD_HALVES),
        .EQ_POST_HALVES     (EQ_POST_HALVES),
        .EQ_LOW_TICKS       (EQ_LOW_TICKS),
        .BROAD_LOW_TICKS    (BROAD_LOW_TICKS),
        .TOP_BLANK_END      (TOP_BLANK_END),
        .BOTTOM_BLANK_START (BOTTOM_BLANK_START)
    ) u_decode (
        .tick (tick_next),
        .line (line_next),
        .seg  (seg_d)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEG_BLANK;
        end else begin
            state_q <= seg_d;
        end
    end

    // Output process
    always_comb begin
        int li;
        li          = int'(line_q);
        level       = LVL_BLACK;
        active_win  = 1'b0;
        line_start  = (tick_q == '0);
        frame_start = (tick_q == '0) && (line_q == '0);
        if (li >= TOP_BLANK_END && li < BOTTOM_BLANK_START) begin
            active_line = AW'(li - TOP_BLANK_END);
        end else begin
            active_line = '0;
        end
        unique case (state_q)
            SEG_HSYNC, SEG_EQ_LO, SEG_BROAD_LO: level = LVL_SYNC;
            SEG_ACTIVE: begin
                level      = {pixel_in, 1'b1};
                active_win = 1'b1;
            end
            SEG_LEFT, SEG_RIGHT, SEG_BLANK, SEG_EQ_HI, SEG_BROAD_HI: level = LVL_BLACK;
            default: level = LVL_BLACK;
        endcase
    end

endmodule

// File: rtl/pal_sync_gen_chk.sv
module pal_sync_gen_chk #(
    parameter int LINE_TICKS  = 640,
    parameter int FRAME_LINES = 312
) (
    input logic       clk,
    input logic       rst,
    input logic       pixel_in,
    input logic [1:0] level,
    input logic       line_start,
    input logic       frame_start,
    input logic       active_win
);

    int   gap;
    logic gap_seen;
    int   lines;
    logic frame_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap        <= 0;
            gap_seen   <= 1'b0;
            lines      <= 0;
            frame_seen <= 1'b0;
        end else begin
            if (line_start) begin
                gap      <= 1;
                gap_seen <= 1'b1;
            end else begin
                gap <= gap + 1;
            end
            if (frame_start) begin
                lines      <= 1;
                frame_seen <= 1'b1;
            end else if (line_start) begin
                lines <= lines + 1;
            end
        end
    end

    // R1: consecutive line strobes are exactly one line apart
    p_line_period_r1: assert property (@(posedge clk) disable iff (rst)
        (line_start && gap_seen) |-> (gap == LINE_TICKS));

    // R1: no second strobe inside a line
    p_line_single_r1: assert property (@(posedge clk) disable iff (rst)
        (gap_seen && gap < LINE_TICKS) |-> !line_start);

    // R2: frame strobe only with a line strobe
    p_frame_on_line_r2: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> line_start);

    // R2: frame length in lines
    p_frame_period_r2: assert property (@(posedge clk) disable iff (rst)
        (frame_start && frame_seen) |-> (lines == FRAME_LINES));

    // R3: every line opens with a sync-level tick
    p_line_opens_sync_r3: assert property (@(posedge clk) disable iff (rst)
        line_start |-> (level == 2'b00));

    // R4: picture window carries the pixel bit over black
    p_window_pixel_r4: assert property (@(posedge clk) disable iff (rst)
        active_win |-> (level == {pixel_in, 1'b1}));

    // R4: the unused code never leaves the block
    p_no_bad_code_r4: assert property (@(posedge clk) disable iff (rst)
        level != 2'b10);

endmodule

bind pal_sync_gen pal_sync_gen_chk #(
    .LINE_TICKS  (LINE_TICKS),
    .FRAME_LINES (FRAME_LINES)
) u_pal_sync_gen_chk (
    .clk         (clk),
    .rst         (rst),
    .pixel_in    (pixel_in),
    .level       (level),
    .line_start  (line_start),
    .frame_start (frame_start),
    .active_win  (active_win)
);

// File: tb/pal_sync_gen_bench.sv
module pal_sync_gen_bench;

    localparam int LT = 640;
    localparam int FL = 312;

    typedef struct {
        logic [1:0] lvl;
        logic       ls;
        logic       fs;
        logic       aw;
        int         al;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pixel_in = 1'b0;
    logic [1:0] level;
    logic       line_start;
    logic       frame_start;
    logic       active_win;
    logic [8:0] active_line;

    int   checks = 0;
    int   errors = 0;
    logic done = 1'b0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    pal_sync_gen u_pal_sync_gen (
        .clk         (clk),
        .rst         (rst),
        .pixel_in    (pixel_in),
        .level       (level),
        .line_start  (line_start),
        .frame_start (frame_start),
        .active_win  (active_win),
        .active_line (active_line)
    );

    // Expected level from the requirement text
    function automatic logic [1:0] exp_level(int t, int l, logic p);
        int half;
        int pos;
        int hidx;
        if (l < 8) begin
            half = t / 320;
            pos  = t % 320;
            hidx = l * 2 + half;
            if (hidx >= 6 && hidx <= 10) return (pos < 273) ? 2'b00 : 2'b01; // R7
            return (pos < 20) ? 2'b00 : 2'b01;                               // R6
        end
        if (t < 40) return 2'b00;
        if (l < 23 || l >= 310) return 2'b01;                               // R5
        if (t >= 160 && t < 600) return {p, 1'b1};                          // R4
        return 2'b01;                                                       // R3
    endfunction

    function automatic string exp_tag(int t, int l);
        int hidx;
        if (l < 8) begin
            hidx = l * 2 + t / 320;
            return (hidx >= 6 && hidx <= 10) ? "R7" : "R6";
        end
        if (l < 23 || l >= 310) return "R5";
        if (t >= 160 && t < 600) return "R4";
        return "R3";
    endfunction

    task automatic push_item(int t, int l, logic p, logic in_reset);
        exp_t e;
        if (in_reset) begin
            e.lvl = 2'b01; e.ls = 1'b0; e.fs = 1'b0; e.aw = 1'b0; e.al = 0;
            e.tag = "R9";
        end else begin
            e.lvl = exp_level(t, l, p);
            e.ls  = (t == 0);
            e.fs  = (t == 0) && (l == 0);
            e.aw  = (l >= 23 && l < 310 && t >= 160 && t < 600);
            e.al  = (l >= 23 && l < 310) ? l - 23 : 0;
            e.tag = exp_tag(t, l);
        end
        sb_q.push_back(e);
    endtask

    task automatic check_field(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    // Monitor: pops one expected item per cycle and compares
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check_field(e.tag, "level", int'(level), int'(e.lvl));
                check_field(e.tag == "R9" ? "R9" : "R1", "line_start", int'(line_start), int'(e.ls));
                check_field(e.tag == "R9" ? "R9" : "R2", "frame_start", int'(frame_start), int'(e.fs));
                check_field(e.tag == "R9" ? "R9" : (e.tag == "R5" ? "R5" : "R4"), "active_win",
                            int'(active_win), int'(e.aw));
                check_field(e.tag == "R9" ? "R9" : "R8", "active_line", int'(active_line), e.al);
            end
        end
    end

    // Driver: reset phase, then one full frame plus the wrap into the next
    initial begin
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            pixel_in = 1'b1;         // R9: ignored while in reset
            push_item(0, 0, 1'b1, 1'b1);
        end
        @(negedge clk);
        rst = 1'b0;
        for (int n = 0; n <= LT * FL + 3; n++) begin
            int   t;
            int   l;
            logic p;
            @(negedge clk);
            t = n % LT;
            l = (n / LT) % FL;
            p = logic'(((t >> 1) ^ l ^ (t >> 4)) & 1);
            pixel_in = p;
            push_item(t, l, p, 1'b0);
        end
        @(negedge clk);
        #2;
        report();
        $finish;
    end

    // Watchdog
    initial begin
        repeat (199_950) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
        $finish;
    end

endmodule